// File: doc/BRIEF.md
# Pipelined SHA-1 Compression Engine

This block computes one SHA-1 compression per clock cycle. Every cycle the caller may present a 512-bit message block that is already padded, together with a 160-bit chaining value and a small opaque tag. A fixed number of cycles later the block returns the 160-bit result: the chaining value added word by word to the output of the 80 compression rounds. The tag and a valid strobe travel with the data, so results leave in the order they entered, one per cycle at full rate. A caller that chains blocks or runs keyed-hash iterations feeds each result back as the next chaining value or message.

There is no controller inside. The pipeline has 83 registered stages. An input buffer isolates the caller's selection logic. A pre-add stage folds the fifth working word, the round constant and the first schedule word into one partial sum. Each of the 80 round stages performs only the remaining additions and prepares the partial sum for the next round. A last stage adds the chaining value. The chaining value and the tag bypass the rounds on a side delay line of matching length.

Top module: `sha1_pipe_engine`

## Requirements
- R1: With the big-endian layout, the result is the SHA-1 compression of the block under the chaining value, with each working word added to the matching chaining word modulo 2^32. Message word 0 sits in `in_block[511:480]` and word 15 in `in_block[31:0]`. Chaining word H0 sits in `in_cv[159:128]` and H4 in `in_cv[31:0]`, and `out_digest` uses the same layout. For example, the padded message "abc" under the standard initial vector yields A9993E36 4706816A BA3E2571 7850C26C 9CD0D89D.
- R2: Any chaining value is accepted, including a digest fed back from an earlier block. The result always uses the chaining value sampled with its own block.
- R3: A block sampled on a rising edge leaves on the 83rd rising edge, counting the sampling edge as the first. `out_valid` is high for exactly the cycle after that edge.
- R4: Blocks may arrive on every consecutive cycle. Each accepted block produces exactly one result. No result is lost or duplicated, and results leave in arrival order.
- R5: `out_tag` equals the `in_tag` that was sampled with the block whose digest is on `out_digest`.
- R6: While `rst_n` is low, and until the first block has had time to pass through, `out_valid` stays low.
- R7: A cycle with `in_valid` low produces no result, whatever is on the data inputs. A gap of idle cycles between two blocks shows up as a gap of the same length between their results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every stage registers on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the valid path |
| in_valid | input | 1 | A block is presented this cycle |
| in_block | input | 512 | Padded message block, word 0 in the top bits |
| in_cv | input | 160 | Chaining value, H0 in the top bits |
| in_tag | input | TAG_W (8) | Caller tag carried with the block |
| out_valid | output | 1 | A result is presented this cycle |
| out_digest | output | 160 | Chaining value plus compressed state, H0 in the top bits |
| out_tag | output | TAG_W (8) | Tag of the block whose result is presented |

## Verification
The assertions assume that the caller keeps `in_valid` low while `rst_n` is low, and that each new block is a fresh sample rather than a held request. The occupancy and idle-window counters are therefore driven only by `in_valid` after reset. The stimulus releases reset with the valid line low. It changes inputs only on the falling edge, and it fills idle cycles with random junk on the data lines, so that a result can come only from a cycle marked valid. Random blocks, chaining values and tags are streamed both back to back and with random gaps, and the results are compared against a bench model of the compression.

// File: rtl/sha1_pipe_pkg.sv
package sha1_pipe_pkg;

    localparam int ROUNDS      = 80;
    localparam int SCHED_WORDS = 16;
    localparam int BLOCK_W     = 512;
    localparam int DIGEST_W    = 160;

    typedef logic [31:0] word_t;

    // Working state handed from stage to stage.
    // p holds e + K + W for the round about to run.
    // w is the schedule window, with w[0] the word for the current round.
    typedef struct packed {
        word_t                  a;
        word_t                  b;
        word_t                  c;
        word_t                  d;
        word_t                  e;
        word_t                  p;
        word_t [SCHED_WORDS-1:0] w;
    } rnd_state_t;

    function automatic word_t round_k(input int t);
        if (t < 20)      return 32'h5A827999;
        else if (t < 40) return 32'h6ED9EBA1;
        else if (t < 60) return 32'h8F1BBCDC;
        else             return 32'hCA62C1D6;
    endfunction

    function automatic word_t round_f(input int t, input word_t x, input word_t y, input word_t z);
        if (t < 20)                 return (x & y) | (~x & z);
        else if (t >= 40 && t < 60) return (x & y) | (x & z) | (y & z);
        else                        return x ^ y ^ z;
    endfunction

endpackage

// File: rtl/sha1_round_stage.sv
module sha1_round_stage
    import sha1_pipe_pkg::*;
#(
    parameter int T = 0
) (
    input  logic       clk,
    input  rnd_state_t st_i,
    output rnd_state_t st_o
);

    rnd_state_t st_d, st_q;
    word_t      sum_w;
    word_t      mix_w;
    logic       unused_e;

    // e already lives inside p, so this stage never reads it
    assign unused_e = ^st_i.e;

    always_comb begin
        sum_w = {st_i.a[26:0], st_i.a[31:27]} + round_f(T, st_i.b, st_i.c, st_i.d) + st_i.p;
        mix_w = st_i.w[13] ^ st_i.w[8] ^ st_i.w[2] ^ st_i.w[0];

        st_d.a = sum_w;
        st_d.b = st_i.a;
        st_d.c = {st_i.b[1:0], st_i.b[31:2]};
        st_d.d = st_i.c;
        st_d.e = st_i.d;

        st_d.w[SCHED_WORDS-2:0] = st_i.w[SCHED_WORDS-1:1];
        st_d.w[SCHED_WORDS-1]   = {mix_w[30:0], mix_w[31]};

        // next round's e is this round's d, next schedule word is w[1]
        st_d.p = st_i.d + round_k(T + 1) + st_i.w[1];
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign st_o = st_q;

endmodule

// File: rtl/sha1_side_delay.sv
module sha1_side_delay #(
    parameter int W     = 168,
    parameter int DEPTH = 81
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);

    logic [DEPTH-1:0] vld_d, vld_q;
    logic [W-1:0]     dat_d [DEPTH];
    logic [W-1:0]     dat_q [DEPTH];

    always_comb begin
        vld_d = {vld_q[DEPTH-2:0], vld_i};
        dat_d[0] = dat_i;
        for (int i = 1; i < DEPTH; i++) begin
            dat_d[i] = dat_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            dat_q[i] <= dat_d[i];
        end
    end

    assign vld_o = vld_q[DEPTH-1];
    assign dat_o = dat_q[DEPTH-1];

endmodule

// File: rtl/sha1_final_add.sv
module sha1_final_add
    import sha1_pipe_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic [DIGEST_W-1:0] cv_i,
    input  logic [TAG_W-1:0]    tag_i,
    input  rnd_state_t          st_i,
    output logic                vld_o,
    output logic [DIGEST_W-1:0] digest_o,
    output logic [TAG_W-1:0]    tag_o
);

    typedef struct packed {
        logic                valid;
        logic [DIGEST_W-1:0] digest;
        logic [TAG_W-1:0]    tag;
    } res_t;

    res_t res_d, res_q;
    logic unused_tail;

    assign unused_tail = ^{st_i.p, st_i.w};

    always_comb begin
        res_d.valid  = vld_i;
        res_d.tag    = tag_i;
        res_d.digest = {cv_i[159:128] + st_i.a,
                        cv_i[127:96]  + st_i.b,
                        cv_i[95:64]   + st_i.c,
                        cv_i[63:32]   + st_i.d,
                        cv_i[31:0]    + st_i.e};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign vld_o    = res_q.valid;
    assign digest_o = res_q.digest;
    assign tag_o    = res_q.tag;

endmodule

// File: rtl/sha1_pipe_engine.sv
module sha1_pipe_engine
    import sha1_pipe_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BLOCK_W-1:0]  in_block,
    input  logic [DIGEST_W-1:0] in_cv,
    input  logic [TAG_W-1:0]    in_tag,
    output logic                out_valid,
    output logic [DIGEST_W-1:0] out_digest,
    output logic [TAG_W-1:0]    out_tag
);

    localparam int STAGES     = ROUNDS + 3;
    localparam int SIDE_DEPTH = ROUNDS + 1;
    localparam int SIDE_W     = DIGEST_W + TAG_W;
    localparam int CNT_W      = $clog2(STAGES + 1) + 1;

    typedef struct packed {
        logic                valid;
        logic [BLOCK_W-1:0]  block;
        logic [DIGEST_W-1:0] cv;
        logic [TAG_W-1:0]    tag;
    } inbuf_t;

    // ---- stage 1: input buffer ----
    inbuf_t buf_d, buf_q;

    always_comb begin
        buf_d.valid = in_valid;
        buf_d.block = in_block;
        buf_d.cv    = in_cv;
        buf_d.tag   = in_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    // ---- stage 2: pre-add of e + K0 + W0 ----
    rnd_state_t pre_d, pre_q;

    always_comb begin
        pre_d.a = buf_q.cv[159:128];
        pre_d.b = buf_q.cv[127:96];
        pre_d.c = buf_q.cv[95:64];
        pre_d.d = buf_q.cv[63:32];
        pre_d.e = buf_q.cv[31:0];
        for (int i = 0; i < SCHED_WORDS; i++) begin
            pre_d.w[i] = buf_q.block[BLOCK_W-1-32*i -: 32];
        end
        pre_d.p = pre_d.e + round_k(0) + pre_d.w[0];
    end

    always_ff @(posedge clk) begin
        pre_q <= pre_d;
    end

    // ---- stages 3..82: one stage per round ----
    rnd_state_t chain [ROUNDS+1];
    assign chain[0] = pre_q;

    for (genvar t = 0; t < ROUNDS; t++) begin : g_round
        sha1_round_stage #(.T(t)) u_round (
            .clk  (clk),
            .st_i (chain[t]),
            .st_o (chain[t+1])
        );
    end

    // ---- side delay: chaining value, tag and valid bypass the rounds ----
    logic              side_vld;
    logic [SIDE_W-1:0] side_dat;

    sha1_side_delay #(.W(SIDE_W), .DEPTH(SIDE_DEPTH)) u_side (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (buf_q.valid),
        .dat_i ({buf_q.tag, buf_q.cv}),
        .vld_o (side_vld),
        .dat_o (side_dat)
    );

    // ---- stage 83: chaining addition ----
    sha1_final_add #(.TAG_W(TAG_W)) u_final (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (side_vld),
        .cv_i     (side_dat[DIGEST_W-1:0]),
        .tag_i    (side_dat[SIDE_W-1:DIGEST_W]),
        .st_i     (chain[ROUNDS]),
        .vld_o    (out_valid),
        .digest_o (out_digest),
        .tag_o    (out_tag)
    );

    // ---- observation counters for the assertions below ----
    typedef struct packed {
        logic [CNT_W-1:0] occ;
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] idle;
    } watch_t;

    watch_t wt_d, wt_q;

    always_comb begin
        wt_d.occ  = wt_q.occ + CNT_W'(in_valid) - CNT_W'(out_valid);
        wt_d.cyc  = (wt_q.cyc >= CNT_W'(STAGES)) ? wt_q.cyc : wt_q.cyc + CNT_W'(1);
        wt_d.idle = in_valid ? '0 :
                    ((wt_q.idle >= CNT_W'(STAGES)) ? wt_q.idle : wt_q.idle + CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wt_q <= '0;
        else        wt_q <= wt_d;
    end

    // R4: no more blocks in flight than there are stages
    a_r4_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wt_q.occ <= CNT_W'(STAGES));

    // R4: every result corresponds to an accepted block
    a_r4_out_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (wt_q.occ != '0));

    // R3 / R6: nothing can come out before the pipeline could have filled
    a_r3_no_early_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (wt_q.cyc >= CNT_W'(STAGES)));

    // R7: a full pipeline length of idle inputs leaves the output quiet
    a_r7_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_q.idle >= CNT_W'(STAGES)) |-> !out_valid);

endmodule

// File: tb/sha1_pipe_engine_tb.sv
module sha1_pipe_engine_tb;

    localparam int LAT = 83;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] in_block = '0;
    logic [159:0] in_cv = '0;
    logic [7:0]   in_tag = '0;
    logic         out_valid;
    logic [159:0] out_digest;
    logic [7:0]   out_tag;

    int tests = 0;
    int fails = 0;
    int edge_n = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [159:0] dig;
        logic [7:0]   tag;
        int           due;
        int           kind;
    } exp_t;

    exp_t expq[$];

    localparam logic [159:0] IV      = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
    localparam logic [159:0] ABC_DIG = 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D;

    sha1_pipe_engine #(.TAG_W(8)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_block   (in_block),
        .in_cv      (in_cv),
        .in_tag     (in_tag),
        .out_valid  (out_valid),
        .out_digest (out_digest),
        .out_tag    (out_tag)
    );

    always #10 clk = ~clk;

    always @(posedge clk) edge_n <= edge_n + 1;

    // ---- behavioural model of one compression ----
    function automatic logic [159:0] ref_compress(input logic [511:0] blk, input logic [159:0] cv);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, x, t;
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 80; i++) begin
            x = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
            w[i] = {x[30:0], x[31]};
        end
        a = cv[159:128]; b = cv[127:96]; c = cv[95:64]; d = cv[63:32]; e = cv[31:0];
        for (int r = 0; r < 80; r++) begin
            if (r < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (r < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (r < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = {a[26:0], a[31:27]} + f + e + k + w[r];
            e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = t;
        end
        return {cv[159:128] + a, cv[127:96] + b, cv[95:64] + c, cv[63:32] + d, cv[31:0] + e};
    endfunction

    function automatic logic [511:0] rand_blk();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom();
        return r;
    endfunction

    function automatic logic [159:0] rand_cv();
        logic [159:0] r;
        for (int i = 0; i < 5; i++) r[32*i +: 32] = $urandom();
        return r;
    endfunction

    task automatic chk_bit(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_vec(input string req, input logic [159:0] act, input logic [159:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle; a valid block records its expected result and arrival edge
    task automatic send(input logic v, input logic [511:0] b, input logic [159:0] c,
                        input logic [7:0] tg, input int kind, input logic [159:0] expd);
        @(negedge clk);
        in_valid = v;
        in_block = b;
        in_cv    = c;
        in_tag   = tg;
        if (v) begin
            exp_t it;
            it.dig  = expd;
            it.tag  = tg;
            it.due  = edge_n + LAT;
            it.kind = kind;
            expq.push_back(it);
        end
    endtask

    task automatic send_idle();
        send(1'b0, rand_blk(), rand_cv(), 8'($urandom()), 0, '0);
    endtask

    task automatic send_rand(input int kind);
        logic [511:0] b;
        logic [159:0] c;
        b = rand_blk();
        c = rand_cv();
        send(1'b1, b, c, 8'($urandom()), kind, ref_compress(b, c));
    endtask

    // ---- output monitor ----
    always @(negedge clk) begin
        exp_t it;
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R7 result with nothing pending: actual out_valid 1 expected 0");
                end else begin
                    it = expq.pop_front();
                    chk_int("R3 R4 arrival edge", edge_n, it.due);
                    case (it.kind)
                        0:       chk_vec("R1 abc digest", out_digest, it.dig);
                        1:       chk_vec("R2 chained digest", out_digest, it.dig);
                        2:       chk_vec("R4 burst digest", out_digest, it.dig);
                        default: chk_vec("R7 gapped digest", out_digest, it.dig);
                    endcase
                    chk_int("R5 tag", int'(out_tag), int'(it.tag));
                end
            end else if (expq.size() != 0 && expq[0].due <= edge_n) begin
                it = expq.pop_front();
                tests++; fails++;
                $display("FAIL R3 missing result: actual none at edge %0d expected due %0d", edge_n, it.due);
            end
        end
    end

    // ---- watchdog ----
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++; tests++;
            $display("FAIL R3 watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---- stimulus ----
    initial begin
        logic [511:0] abc_blk;
        logic [511:0] b2;
        void'($urandom(32'h5EED_0C0D));

        // R6: reset holds the output quiet
        repeat (5) begin
            @(negedge clk);
            chk_bit("R6 out_valid during reset", out_valid, 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        repeat (90) begin
            send_idle();
            chk_bit("R6 out_valid before any block", out_valid, 1'b0);
        end

        // R1: known vector, then R2: chained block under the previous digest
        abc_blk = '0;
        abc_blk[511:480] = 32'h61626380;
        abc_blk[31:0]    = 32'h00000018;
        send(1'b1, abc_blk, IV, 8'hA5, 0, ABC_DIG);
        b2 = rand_blk();
        send(1'b1, b2, ABC_DIG, 8'h5A, 1, ref_compress(b2, ABC_DIG));
        send(1'b1, abc_blk, rand_cv(), 8'h3C, 1, '0);
        // correct the expectation of the last entry with a random chaining value
        expq[expq.size()-1].dig = ref_compress(abc_blk, in_cv);
        send(1'b1, abc_blk, '0, 8'h00, 1, ref_compress(abc_blk, '0));
        send(1'b1, '1, '1, 8'hFF, 1, ref_compress('1, '1));

        // R4: long back-to-back stream
        for (int i = 0; i < 300; i++) send_rand(2);

        // R7: random idle gaps with junk on the data lines
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(1, 0) == 1) send_rand(3);
            else                           send_idle();
        end

        // drain, then everything must have arrived
        repeat (LAT + 20) send_idle();
        chk_int("R4 all results delivered", expq.size(), 0);

        // R7: long idle stretch keeps the output quiet
        repeat (100) begin
            send_idle();
            chk_bit("R7 out_valid while idle", out_valid, 1'b0);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule